// File: doc/BRIEF.md
# Sprite Attribute Block Copy Engine

This block copies a fixed run of bytes from any readable page of the address space into the sprite attribute memory. Software starts a run by presenting a base address with a one-cycle start pulse. After a fixed start latency the engine moves one byte at a time, at a fixed interval. Each byte is read from a dedicated source port that feeds the memory decoder and written to a dedicated port of the sprite attribute memory.

While a run is in progress the engine guards the processor bus. Processor accesses to the high RAM page still reach the decoder unchanged. Every other access is blocked: a blocked read returns all ones, and a blocked write never reaches the decoder. A down-counter that tells how many cycles remain until the next byte write is exposed for the system event scheduler. It sits at its maximum value whenever nothing is pending.

Top module: `oam_dma_engine`

## Requirements
- R1: A start pulse whose base address is greater than 0xF100 changes nothing, whether the engine is idle or running. A base of exactly 0xF100 is accepted.
- R2: An accepted run writes exactly 160 bytes. Destination index k runs from 0 to 159, and byte k carries the source data read at address base+k.
- R3: If the start pulse is sampled at the end of cycle 0, byte k is written in cycle 8+4k. In cycle 1, `next_evt_o` reads 7, and it reads 0 in every write cycle.
- R4: While `busy_o` is high, processor accesses to addresses 0xFF80 through 0xFFFE pass through. Any other address reads as 0xFF, with `bus_re_o` and `bus_we_o` held low.
- R5: `busy_o` is high from the cycle after an accepted start until the cycle of the last write, inclusive. It is low in the cycle that follows.
- R6: While idle, the engine issues no source reads and no destination writes, and `next_evt_o` holds all ones (0xFFFF).
- R7: An accepted start during a run restarts the run from the new base, on the schedule of R3 counted from that request. A byte write that falls in the cycle of the request still completes.
- R8: Each source byte is requested on `src_re_o`/`src_addr_o` in the cycle just before its write. The data is taken from `src_rdata_i` in the write cycle, so the port assumes one cycle of read latency.
- R9: While idle, processor accesses at every address pass to the decoder unchanged, and the read data is returned as is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request |
| start_base_i | input | 16 | Source base address of the run |
| src_re_o | output | 1 | Source read request to the memory decoder |
| src_addr_o | output | 16 | Source read address |
| src_rdata_i | input | 8 | Source read data, one cycle after the request |
| oam_we_o | output | 1 | Sprite attribute memory write enable |
| oam_addr_o | output | 8 | Sprite attribute memory write index |
| oam_wdata_o | output | 8 | Sprite attribute memory write data |
| cpu_re_i | input | 1 | Processor read request |
| cpu_we_i | input | 1 | Processor write request |
| cpu_addr_i | input | 16 | Processor address |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Read data returned to the processor |
| bus_re_o | output | 1 | Filtered read request to the decoder |
| bus_we_o | output | 1 | Filtered write request to the decoder |
| bus_addr_o | output | 16 | Address to the decoder |
| bus_wdata_o | output | 8 | Write data to the decoder |
| bus_rdata_i | input | 8 | Read data from the decoder |
| busy_o | output | 1 | Run in progress; switches the processor filter |
| next_evt_o | output | 16 | Cycles until the next byte write; all ones when idle |

## Verification
The restart request and a byte write can land in the same cycle. The bench provokes this by issuing a new start in exactly the cycle where the third byte of a run is written. It then judges the result from the write log. The third byte must still appear at index 2 with old-source data, and a fresh run of 160 bytes must follow from index 0, with its first write eight cycles after the request. An out-of-range start placed a few cycles later must leave that schedule untouched.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // True when addr lies inside the window [lo, hi]
  function automatic logic in_window(input addr_t addr, input addr_t lo, input addr_t hi);
    return (addr >= lo) && (addr <= hi);
  endfunction

endpackage

// File: rtl/dma_sched.sv
// Cycle-counted scheduler: start latency, byte interval, remaining count.
module dma_sched #(
  parameter int unsigned XFER_LEN    = 160,
  parameter int unsigned FIRST_DELAY = 8,
  parameter int unsigned BYTE_PERIOD = 4,
  parameter int unsigned CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ok_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_rd_o,
  output logic             fire_wr_o
);

  localparam int unsigned REM_W = $clog2(XFER_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_IDLE  = '1;
  localparam logic [CNT_W-1:0] CNT_FIRST = CNT_W'(FIRST_DELAY - 1);
  localparam logic [CNT_W-1:0] CNT_NEXT  = CNT_W'(BYTE_PERIOD - 1);
  localparam logic [REM_W-1:0] REM_FULL  = REM_W'(XFER_LEN);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= CNT_IDLE;
      rem_q  <= '0;
    end else if (start_ok_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_FIRST;
      rem_q  <= REM_FULL;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        if (rem_q == REM_W'(1)) begin
          busy_q <= 1'b0;
          cnt_q  <= CNT_IDLE;
          rem_q  <= '0;
        end else begin
          cnt_q <= CNT_NEXT;
          rem_q <= rem_q - REM_W'(1);
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // Read one cycle ahead of the write so a synchronous source can answer.
  assign fire_rd_o = busy_q && (cnt_q == CNT_W'(1));
  assign fire_wr_o = busy_q && (cnt_q == '0);
  assign busy_o    = busy_q;
  assign cnt_o     = cnt_q;

  AST_IDLE_COUNTER_MAX: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (cnt_q == CNT_IDLE)); // R6

  AST_REMAINING_NONZERO: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (rem_q != '0)); // R2

endmodule

// File: rtl/dma_addr_gen.sv
// Source address and destination index counters.
module dma_addr_gen #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DST_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [DST_W-1:0]  dst_idx_o
);

  logic [ADDR_W-1:0] src_q;
  logic [DST_W-1:0]  dst_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (start_ok_i) begin
      src_q <= base_i;
      dst_q <= '0;
    end else if (step_i) begin
      src_q <= src_q + ADDR_W'(1);
      dst_q <= dst_q + DST_W'(1);
    end
  end

  assign src_addr_o = src_q;
  assign dst_idx_o  = dst_q;

  AST_INDEX_STEPS_ONE: assert property (@(posedge clk) disable iff (rst)
    ($past(step_i) && !$past(start_ok_i) && !$past(rst)) |->
      (dst_q == $past(dst_q) + DST_W'(1))); // R2

endmodule

// File: rtl/cpu_bus_filter.sv
// Processor access guard: only the high RAM window passes while busy.
module cpu_bus_filter
  import oam_dma_pkg::*;
#(
  parameter addr_t WIN_LO    = 16'hFF80,
  parameter addr_t WIN_HI    = 16'hFFFE,
  parameter data_t BLOCK_VAL = 8'hFF
) (
  input  logic  busy_i,
  input  logic  cpu_re_i,
  input  logic  cpu_we_i,
  input  addr_t cpu_addr_i,
  input  data_t cpu_wdata_i,
  output data_t cpu_rdata_o,
  output logic  bus_re_o,
  output logic  bus_we_o,
  output addr_t bus_addr_o,
  output data_t bus_wdata_o,
  input  data_t bus_rdata_i
);

  logic pass;

  always_comb begin
    pass        = !busy_i || in_window(cpu_addr_i, WIN_LO, WIN_HI);
    bus_re_o    = cpu_re_i && pass;
    bus_we_o    = cpu_we_i && pass;
    bus_addr_o  = cpu_addr_i;
    bus_wdata_o = cpu_wdata_i;
    cpu_rdata_o = pass ? bus_rdata_i : BLOCK_VAL;
  end

endmodule

// File: rtl/oam_dma_engine.sv
module oam_dma_engine
  import oam_dma_pkg::*;
#(
  parameter int unsigned XFER_LEN    = 160,
  parameter int unsigned FIRST_DELAY = 8,
  parameter int unsigned BYTE_PERIOD = 4,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DST_W       = 8,
  parameter addr_t       MAX_BASE    = 16'hF100,
  parameter addr_t       HRAM_LO     = 16'hFF80,
  parameter addr_t       HRAM_HI     = 16'hFFFE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [15:0]      start_base_i,
  output logic             src_re_o,
  output logic [15:0]      src_addr_o,
  input  logic [7:0]       src_rdata_i,
  output logic             oam_we_o,
  output logic [7:0]       oam_addr_o,
  output logic [7:0]       oam_wdata_o,
  input  logic             cpu_re_i,
  input  logic             cpu_we_i,
  input  logic [15:0]      cpu_addr_i,
  input  logic [7:0]       cpu_wdata_i,
  output logic [7:0]       cpu_rdata_o,
  output logic             bus_re_o,
  output logic             bus_we_o,
  output logic [15:0]      bus_addr_o,
  output logic [7:0]       bus_wdata_o,
  input  logic [7:0]       bus_rdata_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] next_evt_o
);

  logic start_ok;
  logic fire_rd;
  logic fire_wr;
  logic busy;

  assign start_ok = start_i && (start_base_i <= MAX_BASE);

  dma_sched #(
    .XFER_LEN   (XFER_LEN),
    .FIRST_DELAY(FIRST_DELAY),
    .BYTE_PERIOD(BYTE_PERIOD),
    .CNT_W      (CNT_W)
  ) u_sched (
    .clk       (clk),
    .rst       (rst),
    .start_ok_i(start_ok),
    .busy_o    (busy),
    .cnt_o     (next_evt_o),
    .fire_rd_o (fire_rd),
    .fire_wr_o (fire_wr)
  );

  dma_addr_gen #(
    .ADDR_W(ADDR_W),
    .DST_W (DST_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .start_ok_i(start_ok),
    .base_i    (start_base_i),
    .step_i    (fire_wr),
    .src_addr_o(src_addr_o),
    .dst_idx_o (oam_addr_o)
  );

  cpu_bus_filter #(
    .WIN_LO   (HRAM_LO),
    .WIN_HI   (HRAM_HI),
    .BLOCK_VAL(8'hFF)
  ) u_filter (
    .busy_i     (busy),
    .cpu_re_i   (cpu_re_i),
    .cpu_we_i   (cpu_we_i),
    .cpu_addr_i (cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i),
    .cpu_rdata_o(cpu_rdata_o),
    .bus_re_o   (bus_re_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i)
  );

  assign src_re_o    = fire_rd;
  assign oam_we_o    = fire_wr;
  assign oam_wdata_o = src_rdata_i;
  assign busy_o      = busy;

  AST_BASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    (start_i && (start_base_i > MAX_BASE) && !busy_o) |=> !busy_o); // R1

  AST_START_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (start_i && (start_base_i <= MAX_BASE)) |=>
      (busy_o && (next_evt_o == CNT_W'(FIRST_DELAY - 1)))); // R3

  AST_READ_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
    oam_we_o |-> $past(src_re_o)); // R8

  AST_END_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(oam_we_o) && ($past(oam_addr_o) == DST_W'(XFER_LEN - 1)))); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!oam_we_o && !src_re_o)); // R6

endmodule

// File: tb/oam_dma_engine_tb.sv
module oam_dma_engine_tb;

  localparam int LOGN = 512;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [15:0] start_base_i = '0;
  logic        src_re_o;
  logic [15:0] src_addr_o;
  logic [7:0]  src_rdata_i = '0;
  logic        oam_we_o;
  logic [7:0]  oam_addr_o;
  logic [7:0]  oam_wdata_o;
  logic        cpu_re_i = 1'b0;
  logic        cpu_we_i = 1'b0;
  logic [15:0] cpu_addr_i = '0;
  logic [7:0]  cpu_wdata_i = '0;
  logic [7:0]  cpu_rdata_o;
  logic        bus_re_o;
  logic        bus_we_o;
  logic [15:0] bus_addr_o;
  logic [7:0]  bus_wdata_o;
  logic [7:0]  bus_rdata_i;
  logic        busy_o;
  logic [15:0] next_evt_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  int nw = 0;
  int nr = 0;
  int wa [LOGN];
  int wd [LOGN];
  int wc [LOGN];
  int ra [LOGN];
  int rc [LOGN];

  always #10 clk = ~clk;

  oam_dma_engine u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .start_base_i(start_base_i),
    .src_re_o(src_re_o), .src_addr_o(src_addr_o), .src_rdata_i(src_rdata_i),
    .oam_we_o(oam_we_o), .oam_addr_o(oam_addr_o), .oam_wdata_o(oam_wdata_o),
    .cpu_re_i(cpu_re_i), .cpu_we_i(cpu_we_i), .cpu_addr_i(cpu_addr_i),
    .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .bus_re_o(bus_re_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .next_evt_o(next_evt_o)
  );

  function automatic logic [7:0] src_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  // Source memory model with one cycle of read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_re_o) src_rdata_i <= src_fn(src_addr_o);
  end

  assign bus_rdata_i = bus_addr_o[7:0] ^ 8'h33;

  // Log of destination writes and source reads, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (oam_we_o && nw < LOGN) begin
        wa[nw] = oam_addr_o; wd[nw] = oam_wdata_o; wc[nw] = cyc; nw = nw + 1;
      end
      if (src_re_o && nr < LOGN) begin
        ra[nr] = src_addr_o; rc[nr] = cyc; nr = nr + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic pulse_start(input logic [15:0] base, output int sc);
    @(negedge clk);
    start_i = 1'b1; start_base_i = base; sc = cyc;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(busy_o == 1'b0, "R5", "busy after reset", busy_o, 0);
    check(next_evt_o == 16'hFFFF, "R6", "event counter after reset", next_evt_o, 16'hFFFF);
    check(!oam_we_o && !src_re_o, "R6", "no traffic after reset", oam_we_o, 0);
  endtask

  task automatic t_full(input logic [15:0] base);
    int sc, fc, bad_w, bad_r;
    nw = 0; nr = 0;
    pulse_start(base, sc);
    check(busy_o == 1'b1, "R5", "busy in cycle 1", busy_o, 1);
    check(next_evt_o == 16'd7, "R3", "event counter in cycle 1", next_evt_o, 7);
    wait_idle();
    fc = cyc;
    check(fc == sc + 645, "R5", "busy fall cycle offset", fc - sc, 645);
    check(nw == 160, "R2", "byte count", nw, 160);
    bad_w = 0; bad_r = 0;
    for (int k = 0; k < 160 && k < nw; k++) begin
      if (wa[k] != k || wd[k] != int'(src_fn(base + 16'(k))) || wc[k] != sc + 8 + 4*k)
        bad_w++;
      if (k >= nr || ra[k] != int'(base + 16'(k)) || rc[k] != wc[k] - 1) bad_r++;
    end
    check(bad_w == 0, "R2", "index/data mismatches", bad_w, 0);
    check(bad_w == 0, "R3", "write schedule mismatches", bad_w, 0);
    check(bad_r == 0 && nr == 160, "R8", "source read mismatches", bad_r, 0);
    check(next_evt_o == 16'hFFFF, "R6", "event counter when done", next_evt_o, 16'hFFFF);
    repeat (12) @(negedge clk);
    check(nw == 160 && nr == 160, "R6", "traffic while idle", nw, 160);
  endtask

  task automatic t_reject();
    int sc, hi;
    nw = 0; nr = 0; hi = 0;
    pulse_start(16'hF101, sc);
    for (int i = 0; i < 12; i++) begin
      if (busy_o) hi++;
      @(negedge clk);
    end
    check(hi == 0, "R1", "busy cycles after base 0xF101", hi, 0);
    check(nw == 0 && nr == 0, "R1", "writes after base 0xF101", nw, 0);
    t_full(16'hF100);
  endtask

  task automatic cpu_probe(input logic we, input logic [15:0] a,
                           input bit pass, input string req);
    @(negedge clk);
    cpu_re_i = !we; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = 8'hA5;
    #1;
    if (we) begin
      check(bus_we_o == pass, req, $sformatf("write enable at %h", a), bus_we_o, pass);
    end else begin
      check(bus_re_o == pass, req, $sformatf("read enable at %h", a), bus_re_o, pass);
      check(cpu_rdata_o == (pass ? (a[7:0] ^ 8'h33) : 8'hFF), req,
            $sformatf("read data at %h", a), cpu_rdata_o,
            pass ? (a[7:0] ^ 8'h33) : 8'hFF);
    end
    cpu_re_i = 1'b0; cpu_we_i = 1'b0;
  endtask

  task automatic t_filter();
    int sc;
    pulse_start(16'hC100, sc);
    cpu_probe(1'b0, 16'hC000, 1'b0, "R4");
    cpu_probe(1'b0, 16'hFF80, 1'b1, "R4");
    cpu_probe(1'b0, 16'hFFFE, 1'b1, "R4");
    cpu_probe(1'b0, 16'hFF7F, 1'b0, "R4");
    cpu_probe(1'b0, 16'hFFFF, 1'b0, "R4");
    cpu_probe(1'b1, 16'hC000, 1'b0, "R4");
    cpu_probe(1'b1, 16'hFF90, 1'b1, "R4");
    wait_idle();
    cpu_probe(1'b0, 16'hC000, 1'b1, "R9");
    cpu_probe(1'b0, 16'hFFFF, 1'b1, "R9");
    cpu_probe(1'b1, 16'h8000, 1'b1, "R9");
  endtask

  task automatic t_restart();
    int sc, rc0, bad;
    nw = 0; nr = 0;
    pulse_start(16'hC000, sc);
    while (cyc < sc + 16) @(negedge clk);
    check(oam_we_o == 1'b1, "R7", "write coincides with restart", oam_we_o, 1);
    start_i = 1'b1; start_base_i = 16'hD000; rc0 = cyc;
    @(negedge clk);
    start_i = 1'b0;
    while (cyc < rc0 + 4) @(negedge clk);
    start_i = 1'b1; start_base_i = 16'hF200;   // ignored while busy (R1)
    @(negedge clk);
    start_i = 1'b0;
    wait_idle();
    check(nw == 163, "R7", "total writes across restart", nw, 163);
    bad = 0;
    for (int k = 0; k < 3; k++)
      if (wa[k] != k || wd[k] != int'(src_fn(16'hC000 + 16'(k)))) bad++;
    check(bad == 0 && wc[2] == rc0, "R7", "bytes before restart", bad, 0);
    bad = 0;
    for (int k = 0; k < 160 && 3 + k < nw; k++)
      if (wa[3+k] != k || wd[3+k] != int'(src_fn(16'hD000 + 16'(k))) ||
          wc[3+k] != rc0 + 8 + 4*k) bad++;
    check(bad == 0, "R7", "restarted run mismatches", bad, 0);
    check(bad == 0, "R1", "schedule after rejected start while busy", bad, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full(16'hC000);
    t_reject();
    t_filter();
    t_restart();
    t_full(16'h0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule